// File: doc/BRIEF.md
# Dual-Image Reconfiguration Control Registers

This block is a word-addressed register slave through which software drives a remote-upgrade engine for a device that holds two configuration images. A write to the command offset fires single-cycle pulses that restart the device from its configured image or kick the user watchdog. A write to the select offset records which image to boot and whether that choice overrides the external select input. A write to the request offset queues reads of up to four engine state registers.

The engine is reached through a small serial port. Before each read the block asks the engine to load a frame. It then shifts that frame in one bit per clock, least significant bit first. An image-select write shifts two bits out to the engine and ends with a commit strobe. While any of this is in progress the block raises a busy flag, which software polls at the status offset. The captured results then appear at four result offsets.

Top module: `dimg_ctrl_regs`

## Requirements
- R1: A write to offset 0 with bit 0 set drives `reconfig_pulse` high during the same cycle as the write, for that cycle only. While busy is high the pulse is suppressed.
- R2: A write to offset 0 with bit 1 set drives `wdog_rst_pulse` high during the same cycle as the write, for that cycle only. This holds even while busy is high.
- R3: A write to offset 1 while idle (bit 0 = override enable, bit 1 = image number) makes busy high from the next cycle. The block sends the two bits to the engine, bit 0 first, on two `eng_shift` cycles with `eng_write` high, followed by one `eng_load` commit cycle with `eng_write` high.
- R4: A write to offset 2 while idle takes bits 3:0 as a request mask: bit 0 = watchdog, bit 1 = first previous-state register, bit 2 = second previous-state register, bit 3 = input register. Any combination may be set. Sources are loaded (`eng_load` with `eng_src` = bit index) in ascending order. A zero mask starts nothing.
- R5: Offset 3 bit 0 reads the busy flag. It is high while a select transfer or read request is in progress.
- R6: Writes to offsets 1 and 2 made while busy is high are dropped and change nothing.
- R7: Busy never stays high longer than 531 consecutive cycles for one operation.
- R8: A read frame is 34 bits: bits 28:0 hold the watchdog value, bit 29 the enable, and bits 33:30 the state code. Offsets 4, 5 and 6 (sources 0, 1, 2) return the upper 12 watchdog bits in bits 11:0, the enable in bit 12 and the state code in bits 16:13.
- R9: Offset 7 (source 3) returns frame bit 0 (override enable) in bit 0 and frame bit 1 (image number) in bit 1.
- R10: Reserved and unmapped bits read as zero. Reserved write bits are ignored. `rdata` is valid in the cycle after `rd_en`.
- R11: Offsets 4 to 7 read zero after reset. Each keeps its value until a new read of its own source completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| reconfig_pulse | output | 1 | Reconfiguration trigger |
| wdog_rst_pulse | output | 1 | Watchdog reset trigger |
| eng_load | output | 1 | Frame load (read) or commit (write) strobe |
| eng_shift | output | 1 | Serial shift strobe |
| eng_write | output | 1 | High for select transfer, low for reads |
| eng_src | output | 2 | Source index during a read load |
| eng_dout | output | 1 | Serial data to engine |
| eng_din | input | 1 | Serial data from engine |

## Verification
The hardest situation to reach is a write that lands while a transfer is already running. The drop rule only matters while busy is high. The stimulus therefore queues all four sources, which gives a long busy window. Inside that window it writes a new image select, a new request mask and a command word with both pulse bits set. Afterwards the bench counts the engine loads it saw and re-reads the input register to show that nothing changed except the watchdog pulse.

// File: rtl/dimg_pkg.sv
package dimg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_WSHIFT,
    ST_COMMIT
  } seq_st_t;

  localparam int OFS_CMD   = 0;
  localparam int OFS_SEL   = 1;
  localparam int OFS_RDREQ = 2;
  localparam int OFS_STAT  = 3;
  localparam int OFS_RES0  = 4;
endpackage

// File: rtl/dimg_cmd_decode.sv
module dimg_cmd_decode #(
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int N_SRC = 4
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  output logic             reconfig_pulse,
  output logic             wdog_rst_pulse,
  output logic             sel_start,
  output logic             sel_ovr,
  output logic             sel_img,
  output logic             rd_start,
  output logic [N_SRC-1:0] rd_mask
);
  import dimg_pkg::*;

  logic hit_cmd, hit_sel, hit_req;
  logic unused_wdata;

  assign hit_cmd = wr_en && (addr == AW'(OFS_CMD));
  assign hit_sel = wr_en && (addr == AW'(OFS_SEL));
  assign hit_req = wr_en && (addr == AW'(OFS_RDREQ));

  // only the watchdog kick survives a busy engine
  assign reconfig_pulse = hit_cmd && wdata[0] && !busy;
  assign wdog_rst_pulse = hit_cmd && wdata[1];

  assign sel_start = hit_sel && !busy;
  assign sel_ovr   = wdata[0];
  assign sel_img   = wdata[1];

  assign rd_mask  = wdata[N_SRC-1:0];
  assign rd_start = hit_req && !busy && (|rd_mask);

  assign unused_wdata = ^wdata;
endmodule

// File: rtl/dimg_seq.sv
module dimg_seq #(
  parameter int FRAME_W = 34,
  parameter int SEL_W   = 2,
  parameter int N_SRC   = 4,
  localparam int SW     = $clog2(N_SRC),
  localparam int CW     = $clog2(FRAME_W + 1),
  localparam int SIW    = $clog2(SEL_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_start,
  input  logic               sel_ovr,
  input  logic               sel_img,
  input  logic               rd_start,
  input  logic [N_SRC-1:0]   rd_mask,
  output logic               busy,
  output logic               eng_load,
  output logic               eng_shift,
  output logic               eng_write,
  output logic [SW-1:0]      eng_src,
  output logic               eng_dout,
  input  logic               eng_din,
  output logic               cap_valid,
  output logic [SW-1:0]      cap_src,
  output logic [FRAME_W-1:0] cap_frame
);
  import dimg_pkg::*;

  seq_st_t            state;
  logic [N_SRC-1:0]   pend;
  logic [SW-1:0]      cur_src;
  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] shreg;
  logic [SEL_W-1:0]   wbuf;
  logic [SW-1:0]      next_src;
  logic [N_SRC-1:0]   pend_rest;
  logic               last_bit;

  function automatic logic [SW-1:0] low_idx(input logic [N_SRC-1:0] m);
    logic [SW-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (m[i]) r = SW'(i);
    return r;
  endfunction

  assign next_src  = low_idx(pend);
  assign pend_rest = pend & ~(N_SRC'(1) << cur_src);
  assign last_bit  = (cnt == CW'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= '0;
      cur_src <= '0;
      cnt     <= '0;
      shreg   <= '0;
      wbuf    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (sel_start) begin
            wbuf  <= SEL_W'({sel_img, sel_ovr});
            state <= ST_WSHIFT;
          end else if (rd_start) begin
            pend  <= rd_mask;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          cur_src <= next_src;
          cnt     <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          shreg <= {eng_din, shreg[FRAME_W-1:1]};
          cnt   <= cnt + 1'b1;
          if (last_bit) begin
            pend  <= pend_rest;
            state <= (|pend_rest) ? ST_LOAD : ST_IDLE;
          end
        end
        ST_WSHIFT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SEL_W - 1)) state <= ST_COMMIT;
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign eng_load  = (state == ST_LOAD) || (state == ST_COMMIT);
  assign eng_shift = (state == ST_SHIFT) || (state == ST_WSHIFT);
  assign eng_write = (state == ST_WSHIFT) || (state == ST_COMMIT);
  assign eng_src   = (state == ST_LOAD) ? next_src : cur_src;
  assign eng_dout  = (state == ST_WSHIFT) ? wbuf[cnt[SIW-1:0]] : 1'b0;

  assign cap_valid = (state == ST_SHIFT) && last_bit;
  assign cap_src   = cur_src;
  assign cap_frame = {eng_din, shreg[FRAME_W-1:1]};
endmodule

// File: rtl/dimg_result_bank.sv
module dimg_result_bank #(
  parameter int DW      = 32,
  parameter int N_SRC   = 4,
  parameter int WD_W    = 29,
  parameter int WD_KEEP = 12,
  parameter int ST_W    = 4,
  parameter int SEL_W   = 2,
  localparam int FRAME_W = WD_W + 1 + ST_W,
  localparam int SW      = $clog2(N_SRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cap_valid,
  input  logic [SW-1:0]              cap_src,
  input  logic [FRAME_W-1:0]         cap_frame,
  output logic [N_SRC-1:0][DW-1:0]   res_q
);
  logic unused_frame;
  assign unused_frame = ^cap_frame;

  for (genvar g = 0; g < N_SRC; g++) begin : g_res
    logic [DW-1:0] nxt;
    logic [DW-1:0] res_r;
    if (g < N_SRC - 1) begin : g_wd
      // state code, enable, top watchdog bits
      assign nxt = DW'({cap_frame[FRAME_W-1:WD_W], cap_frame[WD_W-1 -: WD_KEEP]});
    end else begin : g_in
      assign nxt = DW'(cap_frame[SEL_W-1:0]);
    end
    always_ff @(posedge clk) begin
      if (rst)
        res_r <= '0;
      else if (cap_valid && (cap_src == SW'(g)))
        res_r <= nxt;
    end
    assign res_q[g] = res_r;
  end
endmodule

// File: rtl/dimg_ctrl_regs.sv
module dimg_ctrl_regs #(
  parameter int AW      = 3,
  parameter int DW      = 32,
  parameter int N_SRC   = 4,
  parameter int WD_W    = 29,
  parameter int WD_KEEP = 12,
  parameter int ST_W    = 4,
  parameter int SEL_W   = 2,
  localparam int FRAME_W = WD_W + 1 + ST_W,
  localparam int SW      = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          reconfig_pulse,
  output logic          wdog_rst_pulse,
  output logic          eng_load,
  output logic          eng_shift,
  output logic          eng_write,
  output logic [SW-1:0] eng_src,
  output logic          eng_dout,
  input  logic          eng_din
);
  import dimg_pkg::*;

  logic                     busy;
  logic                     sel_start, sel_ovr, sel_img;
  logic                     rd_start;
  logic [N_SRC-1:0]         rd_mask;
  logic                     cap_valid;
  logic [SW-1:0]            cap_src;
  logic [FRAME_W-1:0]       cap_frame;
  logic [N_SRC-1:0][DW-1:0] res_q;
  logic [SW-1:0]            res_idx;

  dimg_cmd_decode #(.AW(AW), .DW(DW), .N_SRC(N_SRC)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .busy(busy),
    .reconfig_pulse(reconfig_pulse), .wdog_rst_pulse(wdog_rst_pulse),
    .sel_start(sel_start), .sel_ovr(sel_ovr), .sel_img(sel_img),
    .rd_start(rd_start), .rd_mask(rd_mask)
  );

  dimg_seq #(.FRAME_W(FRAME_W), .SEL_W(SEL_W), .N_SRC(N_SRC)) u_seq (
    .clk(clk), .rst(rst),
    .sel_start(sel_start), .sel_ovr(sel_ovr), .sel_img(sel_img),
    .rd_start(rd_start), .rd_mask(rd_mask),
    .busy(busy),
    .eng_load(eng_load), .eng_shift(eng_shift), .eng_write(eng_write),
    .eng_src(eng_src), .eng_dout(eng_dout), .eng_din(eng_din),
    .cap_valid(cap_valid), .cap_src(cap_src), .cap_frame(cap_frame)
  );

  dimg_result_bank #(
    .DW(DW), .N_SRC(N_SRC), .WD_W(WD_W), .WD_KEEP(WD_KEEP),
    .ST_W(ST_W), .SEL_W(SEL_W)
  ) u_res (
    .clk(clk), .rst(rst),
    .cap_valid(cap_valid), .cap_src(cap_src), .cap_frame(cap_frame),
    .res_q(res_q)
  );

  assign res_idx = SW'(int'(addr) - OFS_RES0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (int'(addr) == OFS_STAT)
        rdata <= DW'(busy);
      else if (int'(addr) >= OFS_RES0 && int'(addr) < OFS_RES0 + N_SRC)
        rdata <= res_q[res_idx];
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/dimg_ctrl_regs_chk.sv
module dimg_ctrl_regs_chk #(
  parameter int AW       = 3,
  parameter int DW       = 32,
  parameter int BUSY_MAX = 531
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          reconfig_pulse,
  input logic          wdog_rst_pulse,
  input logic          eng_load,
  input logic          eng_shift,
  input logic          busy
);
  logic [15:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  // R1
  reconfig_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    reconfig_pulse |-> !busy);

  // R2
  wdog_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(0) && wdata[1]) |-> wdog_rst_pulse);

  // R3
  sel_busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(1) && !busy) |=> busy);

  // R4
  zero_mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(2) && wdata[3:0] == 4'b0 && !busy) |=> !busy);

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bcnt <= 16'(BUSY_MAX));

  // R10
  stat_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(3)) |=> (rdata[DW-1:1] == '0));

  // R3
  eng_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(eng_load && eng_shift));
endmodule

bind dimg_ctrl_regs dimg_ctrl_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .reconfig_pulse(reconfig_pulse),
  .wdog_rst_pulse(wdog_rst_pulse), .eng_load(eng_load),
  .eng_shift(eng_shift), .busy(busy)
);

// File: tb/dimg_ctrl_regs_test.sv
`timescale 1ns/1ps
module dimg_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        reconfig_pulse, wdog_rst_pulse;
  logic        eng_load, eng_shift, eng_write, eng_dout, eng_din;
  logic [1:0]  eng_src;

  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dimg_ctrl_regs uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .reconfig_pulse(reconfig_pulse),
    .wdog_rst_pulse(wdog_rst_pulse), .eng_load(eng_load),
    .eng_shift(eng_shift), .eng_write(eng_write), .eng_src(eng_src),
    .eng_dout(eng_dout), .eng_din(eng_din)
  );

  // engine stand-in
  logic [33:0] frm [0:2];
  logic [33:0] sr = '0;
  logic [1:0]  win = '0;
  logic        in_img = 1'b0, in_ovr = 1'b0;
  int          nlog = 0;
  int          log_src [0:63];

  function automatic logic [33:0] mkframe(logic [28:0] wd, logic en, logic [3:0] st);
    return {st, en, wd};
  endfunction

  function automatic logic [31:0] expres(logic [33:0] f);
    return {15'b0, f[33:30], f[29], f[28:17]};
  endfunction

  assign eng_din = sr[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eng_load && !eng_write) begin
      sr <= (eng_src == 2'd3) ? {32'b0, in_img, in_ovr} : frm[eng_src];
      log_src[nlog % 64] <= int'(eng_src);
      nlog <= nlog + 1;
    end else if (eng_shift && !eng_write) begin
      sr <= sr >> 1;
    end
    if (eng_shift && eng_write) win <= {eng_dout, win[1]};
    if (eng_load && eng_write) {in_img, in_ovr} <= win;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    do begin
      rd(3'd3, v);
      n++;
    end while (v[0] && n < 1000);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check((a >= 4) ? "R11 reset" : "R10 reset", v, 32'h0);
    end
  endtask

  task automatic t_pulses;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 32'h3;
    #1;
    check("R1 pulse", {31'b0, reconfig_pulse}, 32'h1);
    check("R2 pulse", {31'b0, wdog_rst_pulse}, 32'h1);
    @(negedge clk);
    wdata = 32'hFFFF_FFFC;
    #1;
    check("R10 reserved cmd", {30'b0, reconfig_pulse, wdog_rst_pulse}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    #1;
    check("R1 single cycle", {31'b0, reconfig_pulse}, 32'h0);
  endtask

  task automatic t_sel_write;
    logic [31:0] v;
    int n, base;
    wr(3'd1, 32'hF0 | 32'h2);
    rd(3'd3, v);
    check("R5 busy after select", v, 32'h1);
    wait_idle(n);
    check("R3 engine image", {30'b0, in_img, in_ovr}, 32'h2);
    base = nlog;
    wr(3'd2, 32'h8);
    wait_idle(n);
    check("R4 single load", nlog - base, 1);
    rd(3'd7, v);
    check("R9 offset 7", v, 32'h2);
  endtask

  task automatic t_mask_combo;
    logic [31:0] v;
    int n, base;
    frm[0] = mkframe(29'h1ABC_DEF5, 1'b1, 4'hA);
    frm[1] = mkframe(29'h0123_4567, 1'b0, 4'h3);
    frm[2] = mkframe(29'h1FFF_F000, 1'b1, 4'h6);
    base = nlog;
    wr(3'd2, 32'h5);
    wait_idle(n);
    check("R4 load count", nlog - base, 2);
    check("R4 order first", log_src[base % 64], 0);
    check("R4 order second", log_src[(base + 1) % 64], 2);
    rd(3'd4, v); check("R8 offset 4", v, expres(frm[0]));
    rd(3'd6, v); check("R8 offset 6", v, expres(frm[2]));
    rd(3'd5, v); check("R11 offset 5 untouched", v, 32'h0);
    frm[0] = mkframe(29'h0000_0001, 1'b0, 4'h1);
    frm[1] = mkframe(29'h1555_5555, 1'b1, 4'hF);
    wr(3'd2, 32'hFFFF_FFF2);
    wait_idle(n);
    rd(3'd5, v); check("R8 offset 5", v, expres(frm[1]));
    rd(3'd4, v); check("R11 offset 4 held", v, expres(mkframe(29'h1ABC_DEF5, 1'b1, 4'hA)));
    base = nlog;
    wr(3'd2, 32'h0);
    rd(3'd3, v);
    check("R4 zero mask", v, 32'h0);
    check("R4 zero mask no load", nlog - base, 0);
  endtask

  task automatic t_busy_drop;
    logic [31:0] v;
    int n, base;
    base = nlog;
    wr(3'd2, 32'hF);
    wr(3'd1, 32'h1);
    wr(3'd2, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 32'h3;
    #1;
    check("R1 suppressed while busy", {31'b0, reconfig_pulse}, 32'h0);
    check("R2 honoured while busy", {31'b0, wdog_rst_pulse}, 32'h1);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    wait_idle(n);
    check("R6 no extra load", nlog - base, 4);
    for (int i = 0; i < 4; i++)
      check("R4 ascending", log_src[(base + i) % 64], i);
    check("R6 engine select unchanged", {30'b0, in_img, in_ovr}, 32'h2);
    rd(3'd7, v);
    check("R6 offset 7 unchanged", v, 32'h2);
  endtask

  task automatic t_busy_bound;
    int n;
    wr(3'd2, 32'hF);
    wait_idle(n);
    check("R7 busy bound", (n <= 531) ? 32'h1 : 32'h0, 32'h1);
    check("R7 busy seen", (n > 1) ? 32'h1 : 32'h0, 32'h1);
  endtask

  initial begin
    frm[0] = '0; frm[1] = '0; frm[2] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pulses();
    t_sel_write();
    t_mask_combo();
    t_busy_drop();
    t_busy_bound();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected below 100000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule